// File: doc/BRIEF.md
# Inband Loopback Code Inserter

This block sits on the serial transmit bit stream of a T1/J1 framer, after frame generation. Each input bit arrives with a valid strobe and a marker that flags the framing bit position. When insertion is enabled, the block replaces the stream with a repeating loopback pattern. The pattern is 5 to 8 bits long and is taken from an 8-bit code input. When insertion is disabled, the data passes through unchanged.

Two modes set how the framing bit is treated. In framed mode, the framing bit is passed through as received, and the pattern resumes on the next payload bit without losing its place. In unframed mode, every valid bit, including the framing bit, carries the pattern.

A final maintenance stage can force the whole stream to all ones or to all zeros. The output is registered, one cycle behind the input strobe.

Top module: `lb_code_inserter`

## Requirements
- R1: While rst_ni is low, valid_o and data_o are both 0.
- R2: valid_o equals valid_i of the previous clock cycle.
- R3: With enable_i low and neither force input set, a valid bit appears on data_o unchanged one cycle later.
- R4: With enable_i high, len_sel_i = k selects a pattern length L = 5 + k (00 gives 5, 11 gives 8). The bits sent are code_i[L-1], code_i[L-2] and so on down to code_i[0], and the sequence then repeats without a gap.
- R5: In framed mode (unframed_i = 0), a valid bit with fbit_i = 1 is passed through as received. The pattern position does not advance on that bit.
- R6: In unframed mode (unframed_i = 1), a bit with fbit_i = 1 is replaced by the next pattern bit like any other bit, and the pattern position advances.
- R7: The pattern restarts at code_i[L-1] on the first valid bit after any of these events: a rising edge on enable_i, a change of len_sel_i, or a change of code_i.
- R8: A valid bit with force_ones_i = 1 and force_zeros_i = 0 gives data_o = 1 one cycle later, whatever the mode or enable setting.
- R9: A valid bit with force_zeros_i = 1 gives data_o = 0 one cycle later, even when force_ones_i is also 1.
- R10: A cycle with valid_i = 0 gives data_o = 0 one cycle later. The pattern position does not advance on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input bit strobe |
| data_i | input | 1 | Input bit |
| fbit_i | input | 1 | Input bit is the framing bit |
| enable_i | input | 1 | Loopback code insertion enable |
| unframed_i | input | 1 | 1: the framing bit is also replaced |
| len_sel_i | input | 2 | Pattern length select, L = 5 + len_sel_i |
| code_i | input | 8 | Pattern content, sent from bit L-1 down to bit 0 |
| force_ones_i | input | 1 | Force all-ones on output |
| force_zeros_i | input | 1 | Force all-zeros on output (wins over all-ones) |
| valid_o | output | 1 | Output bit strobe |
| data_o | output | 1 | Output bit |

## Verification
The bench builds the block with its default parameters: an 8-bit code, a 2-bit length select and a minimum length of 5. This makes all four pattern lengths reachable, including the full-width case where the pattern starts at the top bit of the code. The random phase mixes gaps in the valid strobe, framing-bit markers in both modes, and code and length changes in the middle of a pattern. This makes the wrap from the last pattern bit back to the first, the restart and the index hold on framing bits all occur many times against an independent model.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef enum logic [1:0] {
    OUT_PASS  = 2'd0,
    OUT_CODE  = 2'd1,
    OUT_ONES  = 2'd2,
    OUT_ZEROS = 2'd3
  } out_src_e;

  function automatic out_src_e pick_src(input logic zeros, input logic ones,
                                        input logic use_code);
    if (zeros)         return OUT_ZEROS;
    else if (ones)     return OUT_ONES;
    else if (use_code) return OUT_CODE;
    else               return OUT_PASS;
  endfunction
endpackage

// File: rtl/lb_pattern_seq.sv
module lb_pattern_seq #(
  parameter int CODE_W    = 8,
  parameter int LEN_SEL_W = 2,
  parameter int MIN_LEN   = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 fbit_i,
  input  logic                 enable_i,
  input  logic                 unframed_i,
  input  logic [LEN_SEL_W-1:0] len_sel_i,
  input  logic [CODE_W-1:0]    code_i,
  output logic                 use_code_o,
  output logic                 code_bit_o
);
  localparam int CNT_W = $clog2(CODE_W + 1);

  logic                 en_q;
  logic [LEN_SEL_W-1:0] len_q;
  logic [CODE_W-1:0]    code_q;
  logic [CNT_W-1:0]     idx_q, idx_d, cur_idx, len_w, bit_pos;
  logic                 restart, replace, advance;

  assign len_w   = CNT_W'(MIN_LEN) + CNT_W'(len_sel_i);
  assign restart = (enable_i && !en_q) || (len_sel_i != len_q) || (code_i != code_q);
  assign cur_idx = restart ? '0 : idx_q;
  assign replace = unframed_i || !fbit_i;
  assign advance = enable_i && valid_i && replace;
  assign bit_pos = len_w - CNT_W'(1) - cur_idx;

  assign use_code_o = enable_i && replace;
  assign code_bit_o = |(code_i & (CODE_W'(1) << bit_pos));

  always_comb begin
    if (!enable_i)
      idx_d = '0;
    else if (advance)
      idx_d = (cur_idx == len_w - CNT_W'(1)) ? '0 : cur_idx + CNT_W'(1);
    else
      idx_d = cur_idx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      len_q  <= '0;
      code_q <= '0;
      idx_q  <= '0;
    end else begin
      en_q   <= enable_i;
      len_q  <= len_sel_i;
      code_q <= code_i;
      idx_q  <= idx_d;
    end
  end
endmodule

// File: rtl/lb_out_stage.sv
module lb_out_stage
  import lb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic data_i,
  input  logic use_code_i,
  input  logic code_bit_i,
  input  logic force_ones_i,
  input  logic force_zeros_i,
  output logic valid_o,
  output logic data_o
);
  out_src_e src;
  logic     bit_d;

  assign src = pick_src(force_zeros_i, force_ones_i, use_code_i);

  always_comb begin
    unique case (src)
      OUT_ZEROS: bit_d = 1'b0;
      OUT_ONES:  bit_d = 1'b1;
      OUT_CODE:  bit_d = code_bit_i;
      default:   bit_d = data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      data_o  <= valid_i & bit_d;
    end
  end
endmodule

// File: rtl/lb_code_inserter.sv
module lb_code_inserter #(
  parameter int CODE_W    = 8,
  parameter int LEN_SEL_W = 2,
  parameter int MIN_LEN   = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 data_i,
  input  logic                 fbit_i,
  input  logic                 enable_i,
  input  logic                 unframed_i,
  input  logic [LEN_SEL_W-1:0] len_sel_i,
  input  logic [CODE_W-1:0]    code_i,
  input  logic                 force_ones_i,
  input  logic                 force_zeros_i,
  output logic                 valid_o,
  output logic                 data_o
);
  logic use_code, code_bit;

  lb_pattern_seq #(
    .CODE_W(CODE_W), .LEN_SEL_W(LEN_SEL_W), .MIN_LEN(MIN_LEN)
  ) u_seq (
    .clk_i, .rst_ni, .valid_i, .fbit_i, .enable_i, .unframed_i,
    .len_sel_i, .code_i,
    .use_code_o(use_code),
    .code_bit_o(code_bit)
  );

  lb_out_stage u_out (
    .clk_i, .rst_ni, .valid_i, .data_i,
    .use_code_i(use_code),
    .code_bit_i(code_bit),
    .force_ones_i, .force_zeros_i,
    .valid_o, .data_o
  );
endmodule

// File: rtl/lb_code_inserter_chk.sv
module lb_code_inserter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic data_i,
  input logic fbit_i,
  input logic enable_i,
  input logic unframed_i,
  input logic force_ones_i,
  input logic force_zeros_i,
  input logic valid_o,
  input logic data_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_IDLE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !data_o); // R10
  AST_BYPASS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !enable_i && !force_ones_i && !force_zeros_i |=> data_o == $past(data_i)); // R3
  AST_FBIT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && fbit_i && !unframed_i && !force_ones_i && !force_zeros_i
      |=> data_o == $past(data_i)); // R5
  AST_FORCE_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && force_ones_i && !force_zeros_i |=> data_o); // R8
  AST_FORCE_ZEROS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && force_zeros_i |=> !data_o); // R9
endmodule

bind lb_code_inserter lb_code_inserter_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
  .fbit_i(fbit_i), .enable_i(enable_i), .unframed_i(unframed_i),
  .force_ones_i(force_ones_i), .force_zeros_i(force_zeros_i),
  .valid_o(valid_o), .data_o(data_o)
);

// File: tb/test_lb_code_inserter.sv
module test_lb_code_inserter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 0, data_i = 0, fbit_i = 0, enable_i = 0, unframed_i = 0;
  logic force_ones_i = 0, force_zeros_i = 0;
  logic [1:0] len_sel_i = '0;
  logic [7:0] code_i = '0;
  logic valid_o, data_o;

  int checks = 0, failures = 0;
  bit done = 0;

  // model state
  logic m_en = 0;
  logic [1:0] m_len = '0;
  logic [7:0] m_code = '0;
  int m_idx = 0;

  always #4 clk = ~clk;

  lb_code_inserter i_lb_code_inserter (
    .clk_i(clk), .rst_ni(rst_n), .valid_i, .data_i, .fbit_i, .enable_i,
    .unframed_i, .len_sel_i, .code_i, .force_ones_i, .force_zeros_i,
    .valid_o, .data_o
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic d, input logic fb, input logic en,
                     input logic unf, input logic fo, input logic fz,
                     input logic [1:0] ls, input logic [7:0] cd);
    logic exp_d;
    logic rst_ev, repl;
    int cur, len;
    string req;
    @(negedge clk);
    valid_i = v; data_i = d; fbit_i = fb; enable_i = en; unframed_i = unf;
    force_ones_i = fo; force_zeros_i = fz; len_sel_i = ls; code_i = cd;
    len    = 5 + int'(ls);
    rst_ev = (en && !m_en) || (ls != m_len) || (cd != m_code);
    cur    = rst_ev ? 0 : m_idx;
    repl   = unf || !fb;
    if (!v)                exp_d = 1'b0;
    else if (fz)           exp_d = 1'b0;
    else if (fo)           exp_d = 1'b1;
    else if (en && repl)   exp_d = cd[len-1-cur];
    else                   exp_d = d;
    if (!v)                req = "R10";
    else if (fz)           req = "R9";
    else if (fo)           req = "R8";
    else if (!en)          req = "R3";
    else if (fb && !unf)   req = "R5";
    else if (fb)           req = "R6";
    else if (rst_ev)       req = "R7";
    else                   req = "R4";
    if (!en)                  m_idx = 0;
    else if (v && repl)       m_idx = (cur == len - 1) ? 0 : cur + 1;
    else                      m_idx = cur;
    m_en = en; m_len = ls; m_code = cd;
    @(posedge clk);
    #1;
    check("R2", valid_o, v);
    check(req, data_o, exp_d);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    check("R1", valid_o, 1'b0);
    check("R1", data_o, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    // R3 pass-through
    for (int i = 0; i < 12; i++) cyc(1, i[0] ^ i[2], 0, 0, 0, 0, 0, 2'd0, 8'hA5);
    // R4 each length, unframed, with gaps
    for (int l = 0; l < 4; l++) begin
      cyc(1, 0, 0, 0, 1, 0, 0, l[1:0], 8'hB3);
      for (int i = 0; i < 20; i++) cyc(i % 7 != 3, 0, 0, 1, 1, 0, 0, l[1:0], 8'hB3);
    end
    // R5 framed mode, F-bit every 9 bits
    for (int i = 0; i < 40; i++) cyc(1, 1, i % 9 == 4, 1, 0, 0, 0, 2'd1, 8'h2C);
    // R6 unframed mode with F-bit
    for (int i = 0; i < 40; i++) cyc(1, 1, i % 9 == 4, 1, 1, 0, 0, 2'd1, 8'h2C);
    // R7 code change and length change mid-pattern
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 1, 1, 0, 0, 2'd3, i < 5 ? 8'h96 : 8'h69);
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 1, 1, 0, 0, i < 3 ? 2'd3 : 2'd0, 8'h69);
    // R8 / R9
    cyc(1, 0, 0, 0, 0, 1, 0, 2'd0, 8'h69);
    cyc(1, 0, 0, 1, 0, 1, 0, 2'd0, 8'h69);
    cyc(1, 1, 0, 1, 1, 1, 1, 2'd0, 8'h69);
    cyc(1, 1, 0, 0, 0, 0, 1, 2'd0, 8'h69);
    cyc(0, 1, 0, 1, 1, 1, 0, 2'd0, 8'h69);

    // random
    begin
      logic [1:0] ls = 2'd2;
      logic [7:0] cd = 8'h5A;
      logic en = 1, unf = 0;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom % 60 == 0) ls = 2'($urandom);
        if ($urandom % 80 == 0) cd = 8'($urandom);
        if ($urandom % 50 == 0) en = ~en;
        if ($urandom % 200 == 0) unf = ~unf;
        cyc($urandom % 5 != 0, 1'($urandom), $urandom % 12 == 0, en, unf,
            $urandom % 40 == 0, $urandom % 45 == 0, ls, cd);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule